// File: doc/BRIEF.md
# Latching Event Status Register

This block watches an 8-bit word of live condition flags coming from a controller's analog front end and limit logic, and turns every rising edge of a flag into a sticky event bit. Five flags are defined: bit 0 signals an amplifier overload, bit 1 signals that the output sits on its upper limit, bit 2 that it sits on its lower limit, bit 3 that integrator windup protection is holding the integrator, and bit 4 that no setpoint ramp is running (it reads 0 while a ramp is in progress). Bits 5 to 7 carry no meaning and are ignored.

A host reaches the block through a one-request-per-cycle access port. It can fetch the whole event word, which clears every event bit. It can query a single event bit by index, which clears only that bit. It can also write or read an 8-bit enable mask. A separate clear-all strobe wipes the event word. The enabled events are OR-reduced into one summary bit, which a higher-level status byte uses. A small access sequencer with two named states, ST_IDLE and ST_REPLY, issues the replies. A request seen in ST_IDLE moves it to ST_REPLY (transition "accept"). A request seen in ST_REPLY keeps it there ("chain"). A cycle without a request returns it to ST_IDLE ("drain"). The reply is valid exactly while the sequencer sits in ST_REPLY.

Top module: `evt_status_reg`

## Requirements
- R1: Condition inputs at bits 5 to 7 never set an event. Event bits 5 to 7 always read as 0.
- R2: An event bit becomes 1 at the clock edge where its condition bit is sampled 1 after being sampled 0 at the edge before. Bit 0 is overload, bit 1 upper limit, bit 2 lower limit, bit 3 windup hold, and bit 4 ramp stopped.
- R3: When a condition bit falls from 1 to 0, its event bit does not change.
- R4: A set event bit stays set until a read or a clear-all clears it, however long its condition stays low or high.
- R5: Request op 2'b00 (read events) returns, one cycle later on rsp_data, the event word as it was before the request. It then clears every event bit.
- R6: Request op 2'b01 (query bit) with index req_idx returns {7'b0, event[req_idx]} one cycle later. It clears only that bit, and all other event bits keep their value.
- R7: Request op 2'b10 loads the enable mask from req_wdata. Request op 2'b11 returns the mask one cycle later and leaves the events untouched. The mask is 0 after reset and holds its value when it is not written.
- R8: summary equals the OR of (enable mask AND event word) and follows the registered state with no extra delay.
- R9: When clear_all is high at an edge, every event bit clears at that edge.
- R10: If a rising condition edge and a clear (read, bit query or clear-all) fall on the same edge, the event bit ends up set.
- R11: Reset zeroes the event word and the previous-condition register. A condition bit that is already 1 when reset is released sets its event at the first edge.
- R12: rsp_valid is 1 in the cycle after each request and 0 otherwise. rsp_data is 0 while rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_in | input | 8 | Live condition flags |
| clear_all | input | 1 | Clears the whole event word |
| req_valid | input | 1 | Host request strobe, one per cycle |
| req_op | input | 2 | 00 read events, 01 query bit, 10 write mask, 11 read mask |
| req_idx | input | 3 | Bit index for a query |
| req_wdata | input | 8 | Mask value for a mask write |
| rsp_valid | output | 1 | Reply valid, one cycle after a request |
| rsp_data | output | 8 | Reply payload |
| summary | output | 1 | OR of enabled event bits |

## Verification
Suppose an event flop latched on the wrong edge, or failed to clear. The summary bit shows this at the next edge whenever the mask enables that bit. The next read of the event word also shows it, so a single cycle of stimulus followed by one read reveals it. A clear that reaches the wrong bits during a single-bit query shows up in the read that follows. A sequencer stuck in the wrong state shows a missing or extra rsp_valid on the very next cycle. The bench sweeps every pair of consecutive defined-flag patterns and every mask value against an arithmetic model, so each such fault shows within two cycles of the stimulus that triggers it.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

    typedef enum logic [1:0] {
        OP_RD_EVENTS = 2'b00,
        OP_RD_BIT    = 2'b01,
        OP_WR_MASK   = 2'b10,
        OP_RD_MASK   = 2'b11
    } host_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } host_state_e;

endpackage

// File: rtl/evs_edge_latch.sv
module evs_edge_latch #(
    parameter int WIDTH      = 8,
    parameter int FLAG_COUNT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond_in,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] evt_q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < FLAG_COUNT) begin : g_live
            logic prev_q;
            logic bit_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    bit_q  <= 1'b0;
                end else begin
                    prev_q <= cond_in[i];
                    bit_q  <= (bit_q & ~clr_vec[i]) | (cond_in[i] & ~prev_q);
                end
            end

            assign evt_q[i] = bit_q;

            // R2 / R10: a sampled rising edge always leaves the event set
            a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (cond_in[i] && !prev_q) |=> evt_q[i]);

            // R3: a falling condition without a clear leaves the event alone
            a_r3_fall_inert: assert property (@(posedge clk) disable iff (!rst_n)
                (!cond_in[i] && prev_q && !clr_vec[i]) |=> $stable(evt_q[i]));

            // R4: with no clear pending a set bit stays set
            a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_q[i] && !clr_vec[i]) |=> evt_q[i]);
        end else begin : g_dead
            assign evt_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/evs_enable_mask.sv
module evs_enable_mask #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_wdata,
    input  logic [WIDTH-1:0] evt_q,
    output logic [WIDTH-1:0] mask_q,
    output logic             summary
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    always_comb begin
        summary = |(mask_q & evt_q);
    end

    // R7: the mask holds unless written
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

    // R7: a write lands on the next edge
    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R8: no events means no summary
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == '0) |-> !summary);

endmodule

// File: rtl/evs_host_fsm.sv
module evs_host_fsm
    import evt_status_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [WIDTH-1:0] req_wdata,
    input  logic             clear_all,
    input  logic [WIDTH-1:0] evt_q,
    input  logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] clr_vec,
    output logic             mask_we,
    output logic [WIDTH-1:0] mask_wdata,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data
);

    host_state_e state_q, state_d;
    host_op_e    op;
    logic [WIDTH-1:0] reply_d;
    logic [WIDTH-1:0] reply_q;

    assign op = host_op_e'(req_op);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            reply_q <= '0;
        end else begin
            state_q <= state_d;
            reply_q <= reply_d;
        end
    end

    // next state: accept, chain, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs toward the datapath and the reply
    always_comb begin
        clr_vec    = clear_all ? '1 : '0;
        mask_we    = 1'b0;
        mask_wdata = req_wdata;
        reply_d    = '0;
        if (req_valid) begin
            unique case (op)
                OP_RD_EVENTS: begin
                    reply_d = evt_q;
                    clr_vec = '1;
                end
                OP_RD_BIT: begin
                    reply_d = {{(WIDTH-1){1'b0}}, evt_q[req_idx]};
                    clr_vec = clr_vec | (WIDTH'(1) << req_idx);
                end
                OP_WR_MASK: begin
                    mask_we = 1'b1;
                end
                OP_RD_MASK: begin
                    reply_d = mask_q;
                end
                default: reply_d = '0;
            endcase
        end
    end

    assign rsp_valid = (state_q == ST_REPLY);
    assign rsp_data  = reply_q;

    // R12: every request is answered on the next cycle
    a_r12_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12: no reply without a request
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_data == '0));

    // R6: a bit query carries only bit 0
    a_r6_bit_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01) |=> (rsp_data[WIDTH-1:1] == '0));

    // R7: a mask read returns the mask seen at request time
    a_r7_mask_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=> (rsp_data == $past(mask_q)));

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
    parameter int WIDTH      = 8,
    parameter int FLAG_COUNT = 5,
    parameter int IDX_W      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond_in,
    input  logic             clear_all,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    output logic             summary
);

    logic [WIDTH-1:0] evt_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] clr_vec;
    logic             mask_we;
    logic [WIDTH-1:0] mask_wdata;

    evs_edge_latch #(
        .WIDTH      (WIDTH),
        .FLAG_COUNT (FLAG_COUNT)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_in (cond_in),
        .clr_vec (clr_vec),
        .evt_q   (evt_q)
    );

    evs_enable_mask #(
        .WIDTH (WIDTH)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .evt_q      (evt_q),
        .mask_q     (mask_q),
        .summary    (summary)
    );

    evs_host_fsm #(
        .WIDTH (WIDTH),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_idx    (req_idx),
        .req_wdata  (req_wdata),
        .clear_all  (clear_all),
        .evt_q      (evt_q),
        .mask_q     (mask_q),
        .clr_vec    (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    // R5: after a full read only bits whose condition was high may remain
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |=> ((evt_q & ~$past(cond_in)) == '0));

    // R9: after clear-all only bits whose condition was high may remain
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> ((evt_q & ~$past(cond_in)) == '0));

    // R6: a bit query leaves every other set bit set
    a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && !clear_all) |=>
        ((($past(evt_q) & ~(WIDTH'(1) << $past(req_idx))) & ~evt_q) == '0));

    // R1: undefined positions never latch
    a_r1_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (evt_q[WIDTH-1:FLAG_COUNT] == '0));

endmodule

// File: tb/evt_status_reg_tb.sv
module evt_status_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] DEF = 8'h1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond_in = '0;
    logic       clear_all = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [2:0] req_idx = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       summary;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_evt  = '0;
    logic [7:0] m_prev = '0;
    logic [7:0] m_mask = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_status_reg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_in   (cond_in),
        .clear_all (clear_all),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .summary   (summary)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] c, input bit v, input logic [1:0] op,
                        input logic [2:0] idx, input logic [7:0] wd, input bit clr,
                        input string tag);
        logic [7:0] rise;
        logic [7:0] clrv;
        logic [7:0] exp_rsp;
        @(negedge clk);
        cond_in = c; req_valid = v; req_op = op; req_idx = idx;
        req_wdata = wd; clear_all = clr;
        rise    = c & DEF & ~m_prev;
        clrv    = clr ? 8'hFF : 8'h00;
        exp_rsp = 8'h00;
        if (v) begin
            case (op)
                2'b00: begin exp_rsp = m_evt; clrv = 8'hFF; end
                2'b01: begin exp_rsp = {7'b0, m_evt[idx]}; clrv = clrv | (8'h01 << idx); end
                2'b11: exp_rsp = m_mask;
                default: exp_rsp = 8'h00;
            endcase
        end
        m_evt  = (m_evt & ~clrv) | rise;
        m_prev = c & DEF;
        if (v && op == 2'b10) m_mask = wd;
        @(posedge clk);
        #1;
        check("R12 valid", {7'b0, rsp_valid}, {7'b0, v});
        check(tag, rsp_data, exp_rsp);
        check("R8 summary", {7'b0, summary}, {7'b0, |(m_mask & m_evt)});
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state with conditions already high
        cond_in = 8'h1F;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset valid", {7'b0, rsp_valid}, 8'h00);
        check("R11 reset data", rsp_data, 8'h00);
        check("R11 reset summary", {7'b0, summary}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h1F, 0, 2'b00, 3'd0, 8'h00, 0, "R11 idle");
        step(8'h1F, 1, 2'b00, 3'd0, 8'h00, 0, "R11 first edge");

        // R7: mask resets to zero
        step(8'h00, 1, 2'b11, 3'd0, 8'h00, 0, "R7 mask reset");

        // R1: undefined inputs never latch
        step(8'hE0, 0, 2'b00, 3'd0, 8'h00, 0, "R1 idle");
        step(8'h00, 1, 2'b00, 3'd0, 8'h00, 0, "R1 undefined bits");

        // R3: falling condition leaves a cleared event clear
        step(8'h01, 0, 2'b00, 3'd0, 8'h00, 0, "R3 idle");
        step(8'h01, 1, 2'b00, 3'd0, 8'h00, 0, "R3 read");
        step(8'h00, 0, 2'b00, 3'd0, 8'h00, 0, "R3 fall");
        step(8'h00, 1, 2'b00, 3'd0, 8'h00, 0, "R3 after fall");

        // R4: event held through long idle
        step(8'h02, 0, 2'b00, 3'd0, 8'h00, 0, "R4 rise");
        for (int k = 0; k < 20; k++) step(8'h00, 0, 2'b00, 3'd0, 8'h00, 0, "R4 idle");
        step(8'h00, 1, 2'b00, 3'd0, 8'h00, 0, "R4 held");

        // R10: rise coincides with a read and with clear-all
        step(8'h04, 1, 2'b00, 3'd0, 8'h00, 0, "R10 read edge");
        step(8'h04, 1, 2'b00, 3'd0, 8'h00, 0, "R10 kept");
        step(8'h00, 0, 2'b00, 3'd0, 8'h00, 0, "R10 idle");
        step(8'h08, 0, 2'b00, 3'd0, 8'h00, 1, "R10 clear edge");
        step(8'h08, 1, 2'b01, 3'd3, 8'h00, 0, "R10 bit kept");

        // R9: clear-all wipes events
        step(8'h1F, 0, 2'b00, 3'd0, 8'h00, 0, "R9 rise");
        step(8'h00, 0, 2'b00, 3'd0, 8'h00, 0, "R9 fall");
        step(8'h00, 0, 2'b00, 3'd0, 8'h00, 1, "R9 clear");
        step(8'h00, 1, 2'b00, 3'd0, 8'h00, 0, "R9 after clear");

        // R2 / R5: every pair of consecutive defined patterns
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                step(8'(a) | 8'hA0, 1, 2'b00, 3'd0, 8'h00, 0, "R5 read all");
                step(8'(b), 1, 2'b00, 3'd0, 8'h00, 0, "R2 edge pair");
            end
        end

        // R6: single-bit queries over all indexes
        for (int p = 0; p < 32; p++) begin
            step(8'h00, 0, 2'b00, 3'd0, 8'h00, 0, "R6 low");
            step(8'(p), 0, 2'b00, 3'd0, 8'h00, 0, "R6 set");
            for (int i = 0; i < 8; i++) step(8'h00, 1, 2'b01, 3'(i), 8'h00, 0, "R6 bit query");
            step(8'h00, 1, 2'b00, 3'd0, 8'h00, 0, "R6 residue");
        end

        // R7 / R8: every mask value against a full event word
        for (int m = 0; m < 256; m++) begin
            step(8'h00, 1, 2'b10, 3'd0, 8'(m), 0, "R7 write");
            step(8'h00, 1, 2'b11, 3'd0, 8'h00, 0, "R7 mask read");
            step(8'(m) & DEF, 0, 2'b00, 3'd0, 8'h00, 0, "R8 set");
            step(8'h00, 1, 2'b01, 3'(m), 8'h00, 0, "R6 masked query");
            step(8'h00, 0, 2'b00, 3'd0, 8'h00, 1, "R9 clear");
        end

        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            rng = nxt(rng);
            step(rng[7:0], rng[8], rng[10:9], rng[13:11], rng[21:14], (rng[24:22] == 3'd0),
                 "R12 mixed");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule